// File: doc/BRIEF.md
# Second-Operand Shifter

This block forms the second operand of a 32-bit data-processing datapath together with the carry bit that a flag-setting logical operation writes to C. It has two sources. The first is an 8-bit constant rotated right by an even amount. The second is a register value, passed through or shifted by one of four shift types. The shift count comes either from a 5-bit instruction field or from the low byte of a second register. An extra mode rotates right by one bit through the incoming carry. A negate control returns the one's complement of the result, for the move-negated case. The carry bit is not affected by the negate control.

The unit computes its result combinationally and registers it, so it adds one pipeline stage. A caller drives all operand fields with `in_valid` high for one cycle. On the next clock edge, `operand` and `carry_out` take the result and `out_valid` goes high for one cycle. While `in_valid` is low the registered result holds its value.

Top module: `shifter_operand_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `operand` and `carry_out` are all cleared to 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `operand` and `carry_out` change only after a cycle with `in_valid` high.
- R3: With `use_imm`=1, `operand` is `imm_byte` zero-extended and rotated right by 2×`rot_code`. `carry_out` is bit 31 of that result when `rot_code` is nonzero, and `carry_in` when it is zero.
- R4: The register value passes through unchanged with `carry_out`=`carry_in` in two cases: any shift type with a register count of 0 (`cnt_from_reg`=1), and LSL with an immediate count of 0.
- R5: LSL (`shift_kind`=00) by n in 1..31 shifts left and gives bit 32−n as carry. A count of 32 gives 0 with carry bit 0. A count above 32 gives 0 with carry 0.
- R6: LSR (`shift_kind`=01) by n in 1..31 shifts right with zero fill and gives bit n−1 as carry. An immediate count of 0 means 32. A count of 32 gives 0 with carry bit 31. A count above 32 gives 0 with carry 0.
- R7: ASR (`shift_kind`=10) by n in 1..31 shifts right with sign fill and gives bit n−1 as carry. An immediate count of 0 means 32. For counts of 32 or more, every result bit and the carry equal bit 31.
- R8: ROR (`shift_kind`=11) by a nonzero count rotates right by the count modulo 32, with carry equal to bit 31 of the result. When the count is a nonzero multiple of 32, the value is unchanged and the carry is bit 31.
- R9: ROR with an immediate count of 0 is a one-bit rotate through carry. The result is {`carry_in`, value[31:1]} and `carry_out` is value bit 0.
- R10: With `negate`=1, `operand` is the bitwise complement of the result that R3–R9 define, and `carry_out` is the same as with `negate`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand fields are valid this cycle |
| use_imm | input | 1 | 1: rotated constant, 0: register operand |
| imm_byte | input | 8 | Constant for the immediate form |
| rot_code | input | 4 | Rotate code, rotation is twice this value |
| reg_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| cnt_from_reg | input | 1 | 1: count from `cnt_byte`, 0: from `shamt_imm` |
| shamt_imm | input | 5 | Instruction-field shift count |
| cnt_byte | input | 8 | Low byte of the count register |
| carry_in | input | 1 | Current C flag |
| negate | input | 1 | Complement the result |
| out_valid | output | 1 | Registered result valid |
| operand | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The clocked properties assume that every operand field carries a known value whenever `in_valid` is high. They also assume that `rst` is low through the cycle that follows a presented vector. The stimulus meets both conditions: it holds `in_valid` low during reset and drives every field, including the unused ones, with defined values for every vector. Each of the four shift-type codes is legal, so any 2-bit value the stimulus produces exercises a defined path. The stimulus targets each count boundary: 0, 1, 31, 32, 33, large counts and multiples of 32. A pseudo-random sweep fills in the ordinary cases.

// File: rtl/shop_pkg.sv
package shop_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shop_imm_rotator.sv
module shop_imm_rotator #(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] code,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int SH_W = $clog2(W);
  localparam logic [SH_W:0] W_VAL = (SH_W+1)'(W);

  logic [W-1:0]    ext;
  logic [SH_W-1:0] r;
  logic [SH_W:0]   r_inv;

  assign ext   = {{(W-IMM_W){1'b0}}, imm};
  // rotation is twice the code, taken modulo W
  assign r     = SH_W'({code, 1'b0});
  assign r_inv = W_VAL - {1'b0, r};

  always_comb begin
    if (r == '0) begin
      res  = ext;
      cout = cin;
    end else begin
      res  = (ext >> r) | (ext << r_inv);
      cout = res[W-1];
    end
  end
endmodule

// File: rtl/shop_count_decode.sv
module shop_count_decode
  import shop_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic                 cnt_from_reg,
  input  shift_kind_e          kind,
  input  logic [$clog2(W)-1:0] shamt_imm,
  input  logic [CNT_W-1:0]     cnt_byte,
  output logic [CNT_W-1:0]     amt,
  output logic                 rrx
);
  localparam int SH_W = $clog2(W);
  localparam logic [CNT_W-1:0] W_CNT = CNT_W'(W);

  always_comb begin
    amt = '0;
    rrx = 1'b0;
    if (cnt_from_reg) begin
      amt = cnt_byte;
    end else if (shamt_imm != '0) begin
      amt = {{(CNT_W-SH_W){1'b0}}, shamt_imm};
    end else begin
      // a zero field count is re-interpreted per shift type
      unique case (kind)
        SH_LSL:         amt = '0;
        SH_LSR, SH_ASR: amt = W_CNT;
        SH_ROR:         rrx = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
  import shop_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     val,
  input  shift_kind_e      kind,
  input  logic [CNT_W-1:0] amt,
  input  logic             rrx,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int SH_W = $clog2(W);
  localparam logic [SH_W:0] W_VAL = (SH_W+1)'(W);

  logic [W:0]      lsl_w;
  logic [W:0]      lsr_w;
  logic [W:0]      asr_w;
  logic [W-1:0]    ror_w;
  logic [SH_W-1:0] r;
  logic [SH_W:0]   r_inv;

  // one extra bit beside the value catches the last bit shifted out
  assign lsl_w = {1'b0, val} << amt;
  assign lsr_w = {val, 1'b0} >> amt;
  assign asr_w = $signed({val, 1'b0}) >>> amt;
  assign r     = amt[SH_W-1:0];
  assign r_inv = W_VAL - {1'b0, r};
  assign ror_w = (val >> r) | (val << r_inv);

  always_comb begin
    res  = val;
    cout = cin;
    if (rrx) begin
      res  = {cin, val[W-1:1]};
      cout = val[0];
    end else if (amt != '0) begin
      unique case (kind)
        SH_LSL: {cout, res} = lsl_w;
        SH_LSR: {res, cout} = lsr_w;
        SH_ASR: {res, cout} = asr_w;
        SH_ROR: begin
          if (r == '0) begin
            res  = val;
            cout = val[W-1];
          end else begin
            res  = ror_w;
            cout = ror_w[W-1];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import shop_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 use_imm,
  input  logic [IMM_W-1:0]     imm_byte,
  input  logic [ROT_W-1:0]     rot_code,
  input  logic [W-1:0]         reg_val,
  input  logic [1:0]           shift_kind,
  input  logic                 cnt_from_reg,
  input  logic [$clog2(W)-1:0] shamt_imm,
  input  logic [CNT_W-1:0]     cnt_byte,
  input  logic                 carry_in,
  input  logic                 negate,
  output logic                 out_valid,
  output logic [W-1:0]         operand,
  output logic                 carry_out
);
  localparam int SH_W = $clog2(W);

  shift_kind_e      kind;
  logic [W-1:0]     imm_res;
  logic             imm_c;
  logic [CNT_W-1:0] amt;
  logic             rrx;
  logic [W-1:0]     sh_res;
  logic             sh_c;
  logic [W-1:0]     sel_res;
  logic             sel_c;

  assign kind = shift_kind_e'(shift_kind);

  shop_imm_rotator #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm  (imm_byte),
    .code (rot_code),
    .cin  (carry_in),
    .res  (imm_res),
    .cout (imm_c)
  );

  shop_count_decode #(.W(W), .CNT_W(CNT_W)) u_dec (
    .cnt_from_reg (cnt_from_reg),
    .kind         (kind),
    .shamt_imm    (shamt_imm),
    .cnt_byte     (cnt_byte),
    .amt          (amt),
    .rrx          (rrx)
  );

  shop_shift_core #(.W(W), .CNT_W(CNT_W)) u_core (
    .val  (reg_val),
    .kind (kind),
    .amt  (amt),
    .rrx  (rrx),
    .cin  (carry_in),
    .res  (sh_res),
    .cout (sh_c)
  );

  always_comb begin
    sel_res = use_imm ? imm_res : sh_res;
    sel_c   = use_imm ? imm_c   : sh_c;
    if (negate) sel_res = ~sel_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      operand   <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        operand   <= sel_res;
        carry_out <= sel_c;
      end
    end
  end

  // R2: a presented vector produces a valid result one cycle later
  p_valid_next_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2: no vector means the registered result holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));

  // R3: zero rotate code keeps the constant in place and the old carry
  p_imm_norot_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && use_imm && rot_code == '0 && !negate) |=>
      (operand == {{(W-IMM_W){1'b0}}, $past(imm_byte)} && carry_out == $past(carry_in)));

  // R9: one-bit rotate through carry takes bit 0 as the new carry
  p_rrx_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_imm && !cnt_from_reg && shift_kind == 2'b11 && shamt_imm == '0) |=>
      (carry_out == $past(reg_val[0])));

  // R7: arithmetic shift by a register count of W or more spreads the sign
  p_asr_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_imm && cnt_from_reg && shift_kind == 2'b10 &&
     cnt_byte >= CNT_W'(W) && !negate) |=>
      (operand == {W{$past(reg_val[W-1])}} && carry_out == $past(reg_val[W-1])));

  // R5: left shift beyond W clears both result and carry
  p_lsl_far_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_imm && cnt_from_reg && shift_kind == 2'b00 &&
     cnt_byte > CNT_W'(W) && !negate) |=>
      (operand == '0 && !carry_out));

  initial begin
    if (W != (1 << SH_W)) $error("W must be a power of two");
  end
endmodule

// File: tb/test_shifter_operand_unit.sv
`timescale 1ns/1ps
module test_shifter_operand_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        use_imm = 1'b0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  rot_code = '0;
  logic [31:0] reg_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        cnt_from_reg = 1'b0;
  logic [4:0]  shamt_imm = '0;
  logic [7:0]  cnt_byte = '0;
  logic        carry_in = 1'b0;
  logic        negate = 1'b0;
  logic        out_valid;
  logic [31:0] operand;
  logic        carry_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  shifter_operand_unit i_shifter_operand_unit (
    .clk, .rst, .in_valid, .use_imm, .imm_byte, .rot_code, .reg_val,
    .shift_kind, .cnt_from_reg, .shamt_imm, .cnt_byte, .carry_in, .negate,
    .out_valid, .operand, .carry_out
  );

  // reference model built from the requirements, bit by bit
  function automatic logic [32:0] model(bit ui, bit cfr, logic [1:0] k,
      logic [7:0] imm, logic [3:0] rot, logic [31:0] v, logic [4:0] sh,
      logic [7:0] cnt, bit cin, bit neg);
    logic [31:0] val;
    logic        c;
    int          n;
    int          m;
    val = v;
    c   = cin;
    if (ui) begin
      m = 2 * int'(rot);
      for (int i = 0; i < 32; i++) val[i] = (((i + m) % 32) < 8) ? imm[(i + m) % 32] : 1'b0;
      if (m != 0) c = val[31];
    end else begin
      n = cfr ? int'(cnt) : int'(sh);
      if (!cfr && n == 0) begin
        if (k == 2'b01 || k == 2'b10) n = 32;
        else if (k == 2'b11) n = -1;
      end
      if (n == -1) begin
        val = {cin, v[31:1]};
        c   = v[0];
      end else if (n > 0) begin
        case (k)
          2'b00: begin
            for (int i = 0; i < 32; i++) val[i] = (i - n >= 0) ? v[i - n] : 1'b0;
            c = (n <= 32) ? v[32 - n] : 1'b0;
          end
          2'b01: begin
            for (int i = 0; i < 32; i++) val[i] = (i + n < 32) ? v[i + n] : 1'b0;
            c = (n <= 32) ? v[n - 1] : 1'b0;
          end
          2'b10: begin
            for (int i = 0; i < 32; i++) val[i] = (i + n < 32) ? v[i + n] : v[31];
            c = (n <= 32) ? v[n - 1] : v[31];
          end
          default: begin
            m = n % 32;
            if (m == 0) c = v[31];
            else begin
              for (int i = 0; i < 32; i++) val[i] = v[(i + m) % 32];
              c = v[m - 1];
            end
          end
        endcase
      end
    end
    if (neg) val = ~val;
    return {c, val};
  endfunction

  task automatic apply(bit ui, bit cfr, logic [1:0] k, logic [7:0] imm,
      logic [3:0] rot, logic [31:0] v, logic [4:0] sh, logic [7:0] cnt,
      bit cin, bit neg, string tag);
    @(negedge clk);
    in_valid     = 1'b1;
    use_imm      = ui;
    cnt_from_reg = cfr;
    shift_kind   = k;
    imm_byte     = imm;
    rot_code     = rot;
    reg_val      = v;
    shamt_imm    = sh;
    cnt_byte     = cnt;
    carry_in     = cin;
    negate       = neg;
    exp_q.push_back(model(ui, cfr, k, imm, rot, v, sh, cnt, cin, neg));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: out_valid=1 with no vector pending (exp out_valid=0)");
      end else begin
        logic [32:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({carry_out, operand} !== e) begin
          errors++;
          $display("FAIL %s: operand=%h carry=%b exp operand=%h carry=%b",
                   t, operand, carry_out, e[31:0], e[32]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [31:0] held_op;
    logic        held_c;
    repeat (3) @(negedge clk);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || operand !== '0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: vld=%b op=%h c=%b exp vld=0 op=0 c=0", out_valid, operand, carry_out);
    end

    // R3 immediate form
    apply(1, 0, 0, 8'hA5, 4'd0, 0, 0, 0, 1, 0, "R3");
    apply(1, 0, 0, 8'hA5, 4'd0, 0, 0, 0, 0, 0, "R3");
    apply(1, 0, 0, 8'h03, 4'd1, 0, 0, 0, 0, 0, "R3");
    apply(1, 0, 0, 8'hFF, 4'd4, 0, 0, 0, 1, 0, "R3");
    apply(1, 0, 0, 8'h81, 4'd15, 0, 0, 0, 1, 0, "R3");
    apply(1, 0, 0, 8'h40, 4'd1, 0, 0, 0, 1, 0, "R3");
    // R4 zero count pass-through
    apply(0, 0, 2'b00, 0, 0, 32'h8000_0001, 5'd0, 0, 1, 0, "R4");
    apply(0, 1, 2'b01, 0, 0, 32'hDEAD_BEEF, 5'd7, 8'd0, 0, 0, "R4");
    apply(0, 1, 2'b10, 0, 0, 32'h8000_0000, 5'd0, 8'd0, 1, 0, "R4");
    apply(0, 1, 2'b11, 0, 0, 32'h1234_5678, 5'd0, 8'd0, 1, 0, "R4");
    // R5 LSL
    apply(0, 0, 2'b00, 0, 0, 32'hC000_0001, 5'd1, 0, 0, 0, "R5");
    apply(0, 0, 2'b00, 0, 0, 32'h0000_0003, 5'd31, 0, 0, 0, "R5");
    apply(0, 1, 2'b00, 0, 0, 32'h0000_0001, 0, 8'd32, 0, 0, "R5");
    apply(0, 1, 2'b00, 0, 0, 32'hFFFF_FFFF, 0, 8'd33, 1, 0, "R5");
    apply(0, 1, 2'b00, 0, 0, 32'hFFFF_FFFF, 0, 8'd255, 1, 0, "R5");
    // R6 LSR
    apply(0, 0, 2'b01, 0, 0, 32'h8000_0008, 5'd4, 0, 0, 0, "R6");
    apply(0, 0, 2'b01, 0, 0, 32'h8000_0000, 5'd0, 0, 0, 0, "R6");
    apply(0, 1, 2'b01, 0, 0, 32'h8000_0000, 0, 8'd32, 0, 0, "R6");
    apply(0, 1, 2'b01, 0, 0, 32'hFFFF_FFFF, 0, 8'd40, 1, 0, "R6");
    // R7 ASR
    apply(0, 0, 2'b10, 0, 0, 32'h8000_0004, 5'd3, 0, 0, 0, "R7");
    apply(0, 0, 2'b10, 0, 0, 32'h9000_0000, 5'd0, 0, 0, 0, "R7");
    apply(0, 0, 2'b10, 0, 0, 32'h7000_0000, 5'd0, 0, 1, 0, "R7");
    apply(0, 1, 2'b10, 0, 0, 32'h8000_0000, 0, 8'd200, 0, 0, "R7");
    apply(0, 1, 2'b10, 0, 0, 32'h4000_0000, 0, 8'd32, 1, 0, "R7");
    // R8 ROR
    apply(0, 0, 2'b11, 0, 0, 32'h0000_00F1, 5'd8, 0, 0, 0, "R8");
    apply(0, 1, 2'b11, 0, 0, 32'h8765_4321, 0, 8'd64, 0, 0, "R8");
    apply(0, 1, 2'b11, 0, 0, 32'h0000_0100, 0, 8'd41, 0, 0, "R8");
    apply(0, 1, 2'b11, 0, 0, 32'h0000_0001, 0, 8'd32, 1, 0, "R8");
    // R9 rotate through carry
    apply(0, 0, 2'b11, 0, 0, 32'h0000_0003, 5'd0, 0, 1, 0, "R9");
    apply(0, 0, 2'b11, 0, 0, 32'hFFFF_FFFE, 5'd0, 0, 0, 0, "R9");
    // R10 negate
    apply(1, 0, 0, 8'h0F, 4'd2, 0, 0, 0, 0, 1, "R10");
    apply(0, 0, 2'b01, 0, 0, 32'h0000_0011, 5'd1, 0, 0, 1, "R10");
    apply(0, 0, 2'b11, 0, 0, 32'h0000_0001, 5'd0, 0, 0, 1, "R10");

    // pseudo-random sweep across all paths
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      string       t;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a   = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      b   = lcg;
      if (b[2:0] == 3'b111)     t = "R10";
      else if (b[3])            t = "R3";
      else case (b[5:4])
        2'b00: t = "R5";
        2'b01: t = "R6";
        2'b10: t = "R7";
        default: t = "R8";
      endcase
      apply(b[3], b[6], b[5:4], b[15:8], b[19:16], a, b[24:20], b[31:24],
            b[7], b[2:0] == 3'b111, t);
    end

    idle(3);
    // R2: results hold while no vector is presented
    held_op = operand;
    held_c  = carry_out;
    @(negedge clk);
    reg_val  = 32'hFFFF_0000;
    carry_in = ~carry_in;
    use_imm  = 1'b0;
    idle(2);
    vectors++;
    if (out_valid !== 1'b0 || operand !== held_op || carry_out !== held_c) begin
      errors++;
      $display("FAIL R2: vld=%b op=%h c=%b exp vld=0 op=%h c=%b",
               out_valid, operand, carry_out, held_op, held_c);
    end
    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, exp 0", exp_q.size());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule